// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This unit holds the two stack pointers of a small processor core, one for the main stack and one for the process stack, and tracks whether the core is running application code (Thread mode) or servicing exceptions (Handler mode). From the mode and a software stack-select bit it decides which pointer is in use. It applies word-sized push and pop requests to that pointer and emits the memory address and a read or write strobe for each access.

The stack grows downward and the active pointer always addresses the last item stored. A push lowers the pointer by four bytes and writes at the lowered address. A pop reads at the current address and then raises the pointer by four. Nested exceptions are counted, so the core drops back to Thread mode only when the outermost handler returns. Memory, instruction decode and exception arbitration sit outside the unit.

Top module: `bank_sp_unit`

## Requirements
- R1: While reset is low at a rising clock edge, the unit enters Thread mode with the nesting depth at zero and the stack-select bit at zero. The main pointer loads `msp_reset_val` with its two low bits cleared, and the process pointer clears to 0.
- R2: A push (`push`=1, `pop`=0, not suppressed by R10) raises `mem_wr` in the same cycle, with `mem_addr` equal to the active pointer minus 4. From the next cycle the active pointer equals that address.
- R3: A pop (`pop`=1, `push`=0, not suppressed by R10) raises `mem_rd` in the same cycle, with `mem_addr` equal to the active pointer. From the next cycle the active pointer is 4 higher.
- R4: In Thread mode, stack-select 0 makes the main pointer active and 1 makes the process pointer active, as shown on `proc_active`. A `ctrl_sel_we` write takes effect from the next cycle.
- R5: In Handler mode the main pointer is active and `proc_active` is 0, whatever the stack-select bit holds.
- R6: `exc_entry` raises the nesting depth by one and puts the unit in Handler mode from the next cycle. When the depth is already at its maximum of 2^DEPTH_W-1, the entry leaves the depth unchanged.
- R7: `exc_return` lowers a nonzero depth by one, and the unit returns to Thread mode only when the depth reaches zero. A return at depth zero is ignored. When entry and return arrive in the same cycle, only the entry acts.
- R8: A `ctrl_sel_we` write made in Handler mode is ignored, so the old stack-select value applies again once the unit is back in Thread mode.
- R9: `msp_we`/`psp_we` load their pointer with bits [1:0] forced to zero. Each pointer changes only by its own write or by accesses made while it is active.
- R10: A push and a pop requested together produce no strobe and leave the pointers unchanged. The same holds for a push or pop in the same cycle as a direct write to the active pointer, where the written value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| msp_reset_val | input | AW | Value loaded into the main pointer at reset |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ctrl_sel_we | input | 1 | Write strobe for the stack-select bit |
| ctrl_sel_wd | input | 1 | New stack-select value (1 = process stack) |
| push | input | 1 | Push request on the active stack |
| pop | input | 1 | Pop request on the active stack |
| msp_we | input | 1 | Direct write strobe for the main pointer |
| msp_wd | input | AW | Direct write data for the main pointer |
| psp_we | input | 1 | Direct write strobe for the process pointer |
| psp_wd | input | AW | Direct write data for the process pointer |
| handler_mode | output | 1 | 1 in Handler mode, 0 in Thread mode |
| proc_active | output | 1 | 1 when the process pointer is active |
| sp_active | output | AW | Value of the active pointer |
| mem_addr | output | AW | Address of the current push or pop access |
| mem_wr | output | 1 | Write strobe for a push |
| mem_rd | output | 1 | Read strobe for a pop |

## Verification
The bench builds the unit with AW=32 and DEPTH_W=2, which caps the nesting depth at 3. That setting lets a short run saturate the depth counter and then unwind it one return at a time, checking that Thread mode comes back only on the last return. The 32-bit width keeps addresses in a realistic range and lets the pointers wrap across zero on a pop from the top of memory.

// File: rtl/bsp_pkg.sv
// Shared types for the banked stack pointer unit.
// Assumes: a single bit picks between the two pointer banks.
package bsp_pkg;
    typedef enum logic {
        SEL_MAIN = 1'b0,
        SEL_PROC = 1'b1
    } stack_sel_e;
endpackage

// File: rtl/bsp_mode_ctl.sv
// Mode tracker: counts nested exceptions, derives Thread/Handler mode and
// holds the software stack-select bit, which it turns into a bank choice.
// Assumes: strobes are one cycle wide and already prioritised upstream.
module bsp_mode_ctl
    import bsp_pkg::*;
#(
    parameter int DEPTH_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_entry,
    input  logic       exc_return,
    input  logic       ctrl_sel_we,
    input  logic       ctrl_sel_wd,
    output logic       handler_mode,
    output stack_sel_e active_sel
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    logic [DEPTH_W-1:0] depth_q;
    logic               sel_bit_q;

    // Nesting depth: entry wins, saturates at the top, return stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (exc_entry) begin
            if (depth_q != DEPTH_MAX) depth_q <= depth_q + 1'b1;
        end else if (exc_return && depth_q != '0) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    // Stack-select bit: writable only from Thread mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                           sel_bit_q <= 1'b0;
        else if (ctrl_sel_we && !handler_mode) sel_bit_q <= ctrl_sel_wd;
    end

    // Bank choice: Handler mode always uses the main stack.
    always_comb begin
        handler_mode = (depth_q != '0);
        active_sel   = (sel_bit_q && !handler_mode) ? SEL_PROC : SEL_MAIN;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!handler_mode && active_sel == SEL_MAIN));

    p_entry_handler_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> handler_mode);

    p_depth_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && depth_q == DEPTH_MAX) |=> depth_q == DEPTH_MAX);

    p_last_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_entry && depth_q == 1) |=> !handler_mode);

    p_inner_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && depth_q > 1) |=> handler_mode);

    p_sel_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode && ctrl_sel_we) |=> sel_bit_q == $past(sel_bit_q));
endmodule

// File: rtl/bsp_sp_bank.sv
// Pointer bank: two word-aligned stack pointers, push/pop arbitration and
// access address generation for the selected bank.
// Assumes: AW > 2; pointers are stored without their two zero low bits.
module bsp_sp_bank
    import bsp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] msp_reset_val,
    input  stack_sel_e    active_sel,
    input  logic          push,
    input  logic          pop,
    input  logic          msp_we,
    input  logic [AW-1:0] msp_wd,
    input  logic          psp_we,
    input  logic [AW-1:0] psp_wd,
    output logic [AW-1:0] sp_active,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic          mem_rd
);
    localparam int WW    = AW - 2;
    localparam int BANKS = 2;

    logic [BANKS-1:0]         we_v;
    logic [BANKS-1:0][AW-1:0] wd_v;
    logic [BANKS-1:0][WW-1:0] rst_v;
    logic [WW-1:0]            sp_word [BANKS];
    logic [WW-1:0]            act_word;
    logic                     act_we;
    logic                     do_push;
    logic                     do_pop;

    assign we_v  = {psp_we, msp_we};
    assign wd_v  = {psp_wd, msp_wd};
    assign rst_v = {{WW{1'b0}}, msp_reset_val[AW-1:2]};

    // Access arbitration: a lone push or pop, not overridden by a direct write.
    always_comb begin
        act_word = sp_word[active_sel];
        act_we   = we_v[active_sel];
        do_push  = push && !pop && !act_we;
        do_pop   = pop && !push && !act_we;
        mem_wr   = do_push;
        mem_rd   = do_pop;
        mem_addr = {(do_pop ? act_word : act_word - WW'(1)), 2'b00};
        sp_active = {act_word, 2'b00};
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic          here;
        logic [WW-1:0] word_q;
        assign here = (active_sel == stack_sel_e'(b));

        // Pointer register: direct write first, then push or pop when active.
        always_ff @(posedge clk) begin
            if (!rst_n)                word_q <= rst_v[b];
            else if (we_v[b])          word_q <= wd_v[b][AW-1:2];
            else if (here && do_push)  word_q <= word_q - WW'(1);
            else if (here && do_pop)   word_q <= word_q + WW'(1);
        end
        assign sp_word[b] = word_q;
    end

    p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (active_sel != $past(active_sel)) || (sp_active == $past(mem_addr)));

    p_pop_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (active_sel != $past(active_sel)) ||
                   (sp_active == $past(sp_active) + AW'(4)));

    p_main_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel == SEL_PROC && !msp_we) |=> sp_word[0] == $past(sp_word[0]));

    p_proc_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel == SEL_MAIN && !psp_we) |=> sp_word[1] == $past(sp_word[1]));

    p_clash_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |-> (!mem_wr && !mem_rd));
endmodule

// File: rtl/bank_sp_unit.sv
// Banked stack pointer unit top: joins the mode tracker and the pointer bank.
// Assumes: memory accepts one access per strobe in the cycle it is raised.
module bank_sp_unit
    import bsp_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DEPTH_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] msp_reset_val,
    input  logic          exc_entry,
    input  logic          exc_return,
    input  logic          ctrl_sel_we,
    input  logic          ctrl_sel_wd,
    input  logic          push,
    input  logic          pop,
    input  logic          msp_we,
    input  logic [AW-1:0] msp_wd,
    input  logic          psp_we,
    input  logic [AW-1:0] psp_wd,
    output logic          handler_mode,
    output logic          proc_active,
    output logic [AW-1:0] sp_active,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic          mem_rd
);
    stack_sel_e active_sel;

    bsp_mode_ctl #(.DEPTH_W(DEPTH_W)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_entry    (exc_entry),
        .exc_return   (exc_return),
        .ctrl_sel_we  (ctrl_sel_we),
        .ctrl_sel_wd  (ctrl_sel_wd),
        .handler_mode (handler_mode),
        .active_sel   (active_sel)
    );

    bsp_sp_bank #(.AW(AW)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .msp_reset_val (msp_reset_val),
        .active_sel    (active_sel),
        .push          (push),
        .pop           (pop),
        .msp_we        (msp_we),
        .msp_wd        (msp_wd),
        .psp_we        (psp_we),
        .psp_wd        (psp_wd),
        .sp_active     (sp_active),
        .mem_addr      (mem_addr),
        .mem_wr        (mem_wr),
        .mem_rd        (mem_rd)
    );

    assign proc_active = (active_sel == SEL_PROC);

    p_handler_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> !proc_active);
endmodule

// File: tb/sim_bank_sp_unit.sv
module sim_bank_sp_unit;
    localparam int AW = 32;
    localparam int DEPTH_W = 2;
    localparam int DMAX = (1 << DEPTH_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] msp_reset_val = '0;
    logic exc_entry = 0, exc_return = 0, ctrl_sel_we = 0, ctrl_sel_wd = 0;
    logic push = 0, pop = 0, msp_we = 0, psp_we = 0;
    logic [AW-1:0] msp_wd = '0, psp_wd = '0;
    logic handler_mode, proc_active, mem_wr, mem_rd;
    logic [AW-1:0] sp_active, mem_addr;

    always #5 clk = ~clk;

    bank_sp_unit #(.AW(AW), .DEPTH_W(DEPTH_W)) u0 (.*);

    typedef struct {
        string         tag;
        logic          handler;
        logic          proc;
        logic [AW-1:0] active;
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    logic [AW-1:0] m_msp, m_psp;
    int            m_depth;
    logic          m_sel;

    task automatic cmp(string tag, string what, logic [AW-1:0] got, logic [AW-1:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
        end
    endtask

    // monitor: pops one expectation per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "handler_mode", AW'(handler_mode), AW'(e.handler));
                cmp(e.tag, "proc_active", AW'(proc_active), AW'(e.proc));
                cmp(e.tag, "sp_active", sp_active, e.active);
                cmp(e.tag, "mem_wr", AW'(mem_wr), AW'(e.wr));
                cmp(e.tag, "mem_rd", AW'(mem_rd), AW'(e.rd));
                if (e.wr || e.rd) cmp(e.tag, "mem_addr", mem_addr, e.addr);
            end
        end
    end

    task automatic do_reset(logic [AW-1:0] rv);
        @(negedge clk); #1;
        rst_n = 0; msp_reset_val = rv;
        {exc_entry, exc_return, ctrl_sel_we, ctrl_sel_wd, push, pop, msp_we, psp_we} = '0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        m_msp = rv & ~32'h3; m_psp = '0; m_depth = 0; m_sel = 0;
    endtask

    // driver: applies one cycle of inputs and queues the expected outputs
    task automatic step(string tag, logic pu, logic po, logic en, logic rt,
                        logic cwe, logic cwd, logic mwe, logic [AW-1:0] mwd,
                        logic pwe, logic [AW-1:0] pwd);
        exp_t e;
        logic hnd, usep, awe, wr, rd;
        logic [AW-1:0] act;
        @(negedge clk); #1;
        push = pu; pop = po; exc_entry = en; exc_return = rt;
        ctrl_sel_we = cwe; ctrl_sel_wd = cwd;
        msp_we = mwe; msp_wd = mwd; psp_we = pwe; psp_wd = pwd;
        hnd  = (m_depth != 0);
        usep = m_sel && !hnd;
        act  = usep ? m_psp : m_msp;
        awe  = usep ? pwe : mwe;
        wr   = pu && !po && !awe;
        rd   = po && !pu && !awe;
        e.tag = tag; e.handler = hnd; e.proc = usep; e.active = act;
        e.wr = wr; e.rd = rd; e.addr = wr ? act - 4 : act;
        exp_q.push_back(e);
        if (mwe)                 m_msp = mwd & ~32'h3;
        else if (!usep && wr)    m_msp = m_msp - 4;
        else if (!usep && rd)    m_msp = m_msp + 4;
        if (pwe)                 m_psp = pwd & ~32'h3;
        else if (usep && wr)     m_psp = m_psp - 4;
        else if (usep && rd)     m_psp = m_psp + 4;
        if (cwe && !hnd) m_sel = cwd;
        if (en) begin
            if (m_depth != DMAX) m_depth++;
        end else if (rt && m_depth != 0) m_depth--;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        do_reset(32'h2000_0FFF);
        idle("R1 reset state");
        step("R2 push", 1, 0, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R2 push again", 1, 0, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R3 pop", 0, 1, 0, 0, 0, 0, 0, '0, 0, '0);
        idle("R3 after pop");
        step("R9 psp write low bits", 0, 0, 0, 0, 0, 0, 0, '0, 1, 32'h1000_0003);
        idle("R9 main unchanged");
        step("R4 select process", 0, 0, 0, 0, 1, 1, 0, '0, 0, '0);
        idle("R4 process active");
        step("R2 push on process", 1, 0, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R9 msp write while process active", 0, 0, 0, 0, 0, 0, 1, 32'h2000_0802, 0, '0);
        step("R10 push and pop together", 1, 1, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R10 write beats push", 1, 0, 0, 0, 0, 0, 0, '0, 1, 32'h0000_0010);
        step("R10 write beats pop", 0, 1, 0, 0, 0, 0, 0, '0, 1, 32'h0000_0020);
        step("R10 other bank write allows push", 1, 0, 0, 0, 0, 0, 1, 32'h2000_0900, 0, '0);
        for (int i = 0; i < 6; i++) step("R3 pop run", 0, 1, 0, 0, 0, 0, 0, '0, 0, '0);
        for (int i = 0; i < 4; i++) step("R2 push run", 1, 0, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R6 exception entry", 0, 0, 1, 0, 0, 0, 0, '0, 0, '0);
        idle("R5 handler uses main");
        step("R8 select write in handler", 0, 0, 0, 0, 1, 0, 0, '0, 0, '0);
        step("R5 push in handler", 1, 0, 0, 0, 0, 0, 0, '0, 0, '0);
        step("R6 nest two", 0, 0, 1, 0, 0, 0, 0, '0, 0, '0);
        step("R6 nest three", 0, 0, 1, 0, 0, 0, 0, '0, 0, '0);
        step("R6 entry at max", 0, 0, 1, 0, 0, 0, 0, '0, 0, '0);
        step("R7 return one", 0, 0, 0, 1, 0, 0, 0, '0, 0, '0);
        step("R7 entry with return", 0, 0, 1, 1, 0, 0, 0, '0, 0, '0);
        step("R7 return two", 0, 0, 0, 1, 0, 0, 0, '0, 0, '0);
        step("R7 return three", 0, 0, 0, 1, 0, 0, 0, '0, 0, '0);
        step("R7 last return", 0, 0, 0, 1, 0, 0, 0, '0, 0, '0);
        idle("R8 select survived handler");
        step("R7 return in thread", 0, 0, 0, 1, 0, 0, 0, '0, 0, '0);
        idle("R7 still thread");
        step("R4 select main", 0, 0, 0, 0, 1, 0, 0, '0, 0, '0);
        idle("R4 main active");
        step("R3 pop wraps", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFC, 0, '0);
        step("R3 pop at top", 0, 1, 0, 0, 0, 0, 0, '0, 0, '0);
        idle("R3 wrapped");
        do_reset(32'h3000_0001);
        idle("R1 second reset");
        step("R4 select after reset", 0, 0, 0, 0, 1, 1, 0, '0, 0, '0);
        idle("R1 process cleared");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule